// File: doc/BRIEF.md
# Dual-Core Interprocessor FIFO Mailbox

This block connects two processor subsystems, called side A and side B, through two one-way word queues. One queue carries words from A to B and the other carries words from B to A. Each side has a DMA-style data port. On that port the side pushes words into its outgoing queue and pops words from its incoming queue. The port also raises two level pacing requests. One says that the incoming queue holds data, and the other says that the outgoing queue has room. A DMA engine that moves words only while these requests are high can never overrun or starve a queue.

Each side also has a small control port. The side writes a control word to it and reads a status word from it. Setting the request bit of the control word sends a one-cycle interrupt pulse to the opposite side. Software uses this pulse to tell the other side that a queue has filled or drained. If a push hits a full queue or a pop hits an empty queue, the access is dropped and a sticky error flag is set for that side. Software clears the flag with a write-one on the control port.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty. All counts read 0, no error flag or request is set, both interrupt outputs are low, every "has data" request is low and every "has room" request is high.
- R2: Words pushed by one side come out on the other side in the order they were pushed. The head word of a non-empty incoming queue is shown on that side's `rx_data`, and a pop advances to the next word.
- R3: Each queue holds exactly DEPTH (default 8) words. Its fill count never exceeds DEPTH.
- R4: A push into a full queue is dropped: the count and the stored words do not change. The pushing side's error flag is set on the next cycle.
- R5: A pop from an empty queue has no effect on the queue. The popping side's error flag is set on the next cycle.
- R6: The error flag is sticky. A control write with bit 0 set clears it on the next cycle, unless a new fault happens in the same cycle, in which case the flag stays set.
- R7: A control write with bit 8 set makes the opposite side's `ipint` high for exactly the following cycle. Status bit 13 shows the pending request during that cycle only.
- R8: `rx_nempty_req` is high exactly when the incoming count is non-zero. `tx_nfull_req` is high exactly when the outgoing count is below DEPTH.
- R9: A word pushed in cycle t can be read at the receiving side from cycle t+1.
- R10: Status layout, with DEPTH=8 (count width 4): bits [3:0] outgoing count, 4 outgoing full, 5 outgoing empty, [9:6] incoming count, 10 incoming full, 11 incoming empty, 12 error flag, 13 request pending.
- R11: A push and a pop in the same cycle on a full queue remove the head word and drop the push, which sets the error flag. The same pair on a non-empty, non-full queue leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_tx_wr | input | 1 | Side A push into the A-to-B queue |
| a_tx_data | input | DATA_W | Side A push word |
| a_rx_rd | input | 1 | Side A pop from the B-to-A queue |
| a_rx_data | output | DATA_W | Head word of the B-to-A queue |
| a_tx_nfull_req | output | 1 | A-to-B queue has room |
| a_rx_nempty_req | output | 1 | B-to-A queue holds data |
| a_ctl_wr | input | 1 | Side A control write strobe |
| a_ctl_wdata | input | CTL_W | Side A control word (bit 0 error clear, bit 8 interrupt request) |
| a_status | output | ST_W | Side A status word |
| a_ipint | output | 1 | Interrupt pulse to side A |
| b_tx_wr | input | 1 | Side B push into the B-to-A queue |
| b_tx_data | input | DATA_W | Side B push word |
| b_rx_rd | input | 1 | Side B pop from the A-to-B queue |
| b_rx_data | output | DATA_W | Head word of the A-to-B queue |
| b_tx_nfull_req | output | 1 | B-to-A queue has room |
| b_rx_nempty_req | output | 1 | A-to-B queue holds data |
| b_ctl_wr | input | 1 | Side B control write strobe |
| b_ctl_wdata | input | CTL_W | Side B control word (bit 0 error clear, bit 8 interrupt request) |
| b_status | output | ST_W | Side B status word |
| b_ipint | output | 1 | Interrupt pulse to side B |

## Verification
The assertions assume that every input is a known value on each clock edge once reset is released. They also assume that control-word bits other than 0 and 8 carry no meaning, so those bits are left unchecked. The stimulus drives all inputs from tasks on the falling edge and holds them at zero during reset. The bench also pushes into full queues and pops from empty ones on purpose, because those cases are the subject of R4 and R5 and not a breach of the input assumptions.

// File: rtl/ipc_mbox_pkg.sv
// Shared constants for the interprocessor mailbox.
// Assumes: control-word bit positions are fixed by the software contract.
package ipc_mbox_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_DEPTH  = 8;
    localparam int DEF_CTL_W  = 16;
    localparam int REQ_BIT    = 8;   // control bit that raises the cross interrupt
    localparam int CLR_BIT    = 0;   // control bit that clears the error flag (write one)

    // Flag pair reported for one queue.
    typedef struct packed {
        logic full;
        logic empty;
    } q_flags_t;
endpackage

// File: rtl/ipc_word_fifo.sv
// One-way word queue with a registered fill count.
// Shows the head word combinationally (first word falls through).
// Dropped accesses are reported on push_drop / pop_drop.
// Assumes: DEPTH >= 2. Fullness and emptiness are judged on the state before the edge.
module ipc_word_fifo
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output q_flags_t          flags,
    output logic              push_drop,
    output logic              pop_drop
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Decide which accesses are accepted and which are dropped.
    always_comb begin
        flags.full  = (count == FULL_CNT);
        flags.empty = (count == '0);
        do_push     = push && !flags.full;
        do_pop      = pop && !flags.empty;
        push_drop   = push && flags.full;
        pop_drop    = pop && flags.empty;
        head        = mem[rd_ptr];
    end

    // Store accepted words (storage needs no reset).
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ipc_side_ctl.sv
// Per-side control state: the sticky error flag and the self-clearing interrupt request.
// Assumes: fault is the OR of that side's dropped push and dropped pop.
module ipc_side_ctl
    import ipc_mbox_pkg::*;
#(
    parameter int CTL_W = DEF_CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             fault,
    output logic             err,
    output logic             req
);
    // Sticky error: a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (fault) begin
            err <= 1'b1;
        end else if (ctl_wr && ctl_wdata[CLR_BIT]) begin
            err <= 1'b0;
        end
    end

    // Request bit lives for a single cycle after the write that set it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= ctl_wr && ctl_wdata[REQ_BIT];
        end
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Two-way interprocessor mailbox: two one-way word queues and a symmetric control plane.
// Side A pushes into queue 0 and pops queue 1; side B does the reverse.
// Assumes: synchronous active-low reset, one clock for both sides.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int CTL_W  = DEF_CTL_W,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int ST_W  = 2 * CW + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_tx_wr,
    input  logic [DATA_W-1:0] a_tx_data,
    input  logic              a_rx_rd,
    output logic [DATA_W-1:0] a_rx_data,
    output logic              a_tx_nfull_req,
    output logic              a_rx_nempty_req,
    input  logic              a_ctl_wr,
    input  logic [CTL_W-1:0]  a_ctl_wdata,
    output logic [ST_W-1:0]   a_status,
    output logic              a_ipint,
    input  logic              b_tx_wr,
    input  logic [DATA_W-1:0] b_tx_data,
    input  logic              b_rx_rd,
    output logic [DATA_W-1:0] b_rx_data,
    output logic              b_tx_nfull_req,
    output logic              b_rx_nempty_req,
    input  logic              b_ctl_wr,
    input  logic [CTL_W-1:0]  b_ctl_wdata,
    output logic [ST_W-1:0]   b_status,
    output logic              b_ipint
);
    // Index 0 = side A, index 1 = side B. Queue i is the one side i pushes into.
    logic              s_push  [2];
    logic [DATA_W-1:0] s_wdata [2];
    logic              s_pop   [2];
    logic              s_cwr   [2];
    logic [CTL_W-1:0]  s_cdata [2];
    logic [DATA_W-1:0] q_head  [2];
    logic [CW-1:0]     q_cnt   [2];
    q_flags_t          q_flg   [2];
    logic              q_pdrop [2];
    logic              q_rdrop [2];
    logic              s_err   [2];
    logic              s_req   [2];
    logic [ST_W-1:0]   s_stat  [2];

    // Gather the per-side inputs into indexed form.
    always_comb begin
        s_push[0]  = a_tx_wr;   s_push[1]  = b_tx_wr;
        s_wdata[0] = a_tx_data; s_wdata[1] = b_tx_data;
        s_pop[0]   = a_rx_rd;   s_pop[1]   = b_rx_rd;
        s_cwr[0]   = a_ctl_wr;  s_cwr[1]   = b_ctl_wr;
        s_cdata[0] = a_ctl_wdata; s_cdata[1] = b_ctl_wdata;
    end

    for (genvar i = 0; i < 2; i++) begin : g_side
        localparam int O = 1 - i;  // the opposite side

        // Queue i: written by side i, read by side O.
        ipc_word_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (s_push[i]),
            .push_data (s_wdata[i]),
            .pop       (s_pop[O]),
            .head      (q_head[i]),
            .count     (q_cnt[i]),
            .flags     (q_flg[i]),
            .push_drop (q_pdrop[i]),
            .pop_drop  (q_rdrop[i])
        );

        // Side i faults on its own dropped push or its dropped pop of queue O.
        ipc_side_ctl #(
            .CTL_W (CTL_W)
        ) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (s_cwr[i]),
            .ctl_wdata (s_cdata[i]),
            .fault     (q_pdrop[i] | q_rdrop[O]),
            .err       (s_err[i]),
            .req       (s_req[i])
        );

        // Pack the side's status word: outgoing queue low, incoming queue above it.
        always_comb begin
            s_stat[i] = {s_req[i], s_err[i],
                         q_flg[O].empty, q_flg[O].full, q_cnt[O],
                         q_flg[i].empty, q_flg[i].full, q_cnt[i]};
        end
    end

    // Drive the ports from the indexed results.
    always_comb begin
        a_rx_data       = q_head[1];
        b_rx_data       = q_head[0];
        a_tx_nfull_req  = !q_flg[0].full;
        b_tx_nfull_req  = !q_flg[1].full;
        a_rx_nempty_req = !q_flg[1].empty;
        b_rx_nempty_req = !q_flg[0].empty;
        a_status        = s_stat[0];
        b_status        = s_stat[1];
        a_ipint         = s_req[1];
        b_ipint         = s_req[0];
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Property checker for ipc_mailbox, attached with bind. Observes ports only.
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int CTL_W = DEF_CTL_W,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int ST_W = 2 * CW + 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_tx_wr,
    input logic             a_rx_rd,
    input logic             a_ctl_wr,
    input logic [CTL_W-1:0] a_ctl_wdata,
    input logic [ST_W-1:0]  a_status,
    input logic             a_ipint,
    input logic             a_tx_nfull_req,
    input logic             a_rx_nempty_req,
    input logic             b_tx_wr,
    input logic             b_rx_rd,
    input logic             b_ctl_wr,
    input logic [CTL_W-1:0] b_ctl_wdata,
    input logic [ST_W-1:0]  b_status,
    input logic             b_ipint,
    input logic             b_tx_nfull_req,
    input logic             b_rx_nempty_req
);
    localparam int TXF = CW;
    localparam int RXE = 2 * CW + 3;
    localparam int ERR = 2 * CW + 4;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_status[CW-1:0] <= CW'(DEPTH) && b_status[CW-1:0] <= CW'(DEPTH));

    p_full_push_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tx_wr && a_status[TXF]) |=> a_status[ERR]);

    p_empty_pop_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rx_rd && b_status[RXE]) |=> b_status[ERR]);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_status[ERR] && !(a_ctl_wr && a_ctl_wdata[CLR_BIT])) |=> a_status[ERR]);

    p_ipint_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ctl_wr && a_ctl_wdata[REQ_BIT]) |=> b_ipint);

    p_ipint_b_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ctl_wr && a_ctl_wdata[REQ_BIT]) |=> !b_ipint);

    p_ipint_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ctl_wr && b_ctl_wdata[REQ_BIT]) |=> a_ipint);

    p_pace_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_tx_nfull_req == (b_status[2*CW+1:CW+2] != CW'(DEPTH)));

    p_pace_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_rx_nempty_req == (b_status[CW-1:0] != '0));

    p_push_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_tx_wr && b_tx_nfull_req && !a_rx_rd) |=> a_rx_nempty_req);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .DEPTH (DEPTH),
    .CTL_W (CTL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .a_tx_wr         (a_tx_wr),
    .a_rx_rd         (a_rx_rd),
    .a_ctl_wr        (a_ctl_wr),
    .a_ctl_wdata     (a_ctl_wdata),
    .a_status        (a_status),
    .a_ipint         (a_ipint),
    .a_tx_nfull_req  (a_tx_nfull_req),
    .a_rx_nempty_req (a_rx_nempty_req),
    .b_tx_wr         (b_tx_wr),
    .b_rx_rd         (b_rx_rd),
    .b_ctl_wr        (b_ctl_wr),
    .b_ctl_wdata     (b_ctl_wdata),
    .b_status        (b_status),
    .b_ipint         (b_ipint),
    .b_tx_nfull_req  (b_tx_nfull_req),
    .b_rx_nempty_req (b_rx_nempty_req)
);

// File: tb/ipc_mailbox_bench.sv
// Self-checking bench: behavioural queue model compared on every clock.
module ipc_mailbox_bench;
    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int CTLW = 16;
    localparam int SW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic          a_tx_wr = 0, a_rx_rd = 0, a_ctl_wr = 0;
    logic [DW-1:0] a_tx_data = '0;
    logic [CTLW-1:0] a_ctl_wdata = '0;
    logic          b_tx_wr = 0, b_rx_rd = 0, b_ctl_wr = 0;
    logic [DW-1:0] b_tx_data = '0;
    logic [CTLW-1:0] b_ctl_wdata = '0;
    logic [DW-1:0] a_rx_data, b_rx_data;
    logic          a_tx_nfull_req, a_rx_nempty_req, b_tx_nfull_req, b_rx_nempty_req;
    logic [SW-1:0] a_status, b_status;
    logic          a_ipint, b_ipint;

    ipc_mailbox u_ipc_mailbox (.*);

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] qab[$];
    logic [DW-1:0] qba[$];
    bit m_err_a = 0, m_err_b = 0, m_req_a = 0, m_req_b = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] exp_stat(int txc, int rxc, bit err, bit req);
        logic [SW-1:0] s;
        s[3:0] = 4'(txc); s[4] = (txc == DEPTH); s[5] = (txc == 0);
        s[9:6] = 4'(rxc); s[10] = (rxc == DEPTH); s[11] = (rxc == 0);
        s[12] = err; s[13] = req;
        return s;
    endfunction

    // Reference model step from the inputs currently driven.
    task automatic model_step();
        bit ab_full = (qab.size() == DEPTH), ab_empty = (qab.size() == 0);
        bit ba_full = (qba.size() == DEPTH), ba_empty = (qba.size() == 0);
        bit fa = (a_tx_wr && ab_full) || (a_rx_rd && ba_empty);
        bit fb = (b_tx_wr && ba_full) || (b_rx_rd && ab_empty);
        if (b_rx_rd && !ab_empty) void'(qab.pop_front());
        if (a_tx_wr && !ab_full) qab.push_back(a_tx_data);
        if (a_rx_rd && !ba_empty) void'(qba.pop_front());
        if (b_tx_wr && !ba_full) qba.push_back(b_tx_data);
        if (fa) m_err_a = 1; else if (a_ctl_wr && a_ctl_wdata[0]) m_err_a = 0;
        if (fb) m_err_b = 1; else if (b_ctl_wr && b_ctl_wdata[0]) m_err_b = 0;
        m_req_a = a_ctl_wr && a_ctl_wdata[8];
        m_req_b = b_ctl_wr && b_ctl_wdata[8];
    endtask

    task automatic compare_all();
        chk("R10 a_status", 32'(a_status), 32'(exp_stat(qab.size(), qba.size(), m_err_a, m_req_a)));
        chk("R10 b_status", 32'(b_status), 32'(exp_stat(qba.size(), qab.size(), m_err_b, m_req_b)));
        chk("R7 b_ipint", 32'(b_ipint), 32'(m_req_a));
        chk("R7 a_ipint", 32'(a_ipint), 32'(m_req_b));
        chk("R8 a_tx_nfull_req", 32'(a_tx_nfull_req), 32'(qab.size() < DEPTH));
        chk("R8 b_rx_nempty_req", 32'(b_rx_nempty_req), 32'(qab.size() != 0));
        chk("R8 b_tx_nfull_req", 32'(b_tx_nfull_req), 32'(qba.size() < DEPTH));
        chk("R8 a_rx_nempty_req", 32'(a_rx_nempty_req), 32'(qba.size() != 0));
        if (qab.size() != 0) chk("R2 b_rx_data", 32'(b_rx_data), 32'(qab[0]));
        if (qba.size() != 0) chk("R2 a_rx_data", 32'(a_rx_data), 32'(qba[0]));
    endtask

    // One clock: update model, wait past the edge, compare, clear strobes.
    task automatic cyc();
        model_step();
        @(negedge clk);
        compare_all();
        a_tx_wr = 0; a_rx_rd = 0; a_ctl_wr = 0; a_ctl_wdata = '0;
        b_tx_wr = 0; b_rx_rd = 0; b_ctl_wr = 0; b_ctl_wdata = '0;
    endtask

    task automatic push_a(input logic [DW-1:0] d);
        a_tx_wr = 1; a_tx_data = d; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 a_status", 32'(a_status), 32'(exp_stat(0, 0, 0, 0)));
        chk("R1 b_status", 32'(b_status), 32'(exp_stat(0, 0, 0, 0)));
        chk("R1 ipint", 32'({a_ipint, b_ipint}), 32'(0));
        chk("R1 pacing", 32'({a_tx_nfull_req, a_rx_nempty_req, b_tx_nfull_req, b_rx_nempty_req}), 32'b1010);

        // R9: one push visible the next cycle
        push_a(16'hA001);
        chk("R9 b_rx_data", 32'(b_rx_data), 32'h0000A001);
        chk("R9 b_rx_nempty_req", 32'(b_rx_nempty_req), 32'd1);
        push_a(16'hA002); push_a(16'hA003);
        // R2: ordered drain
        for (int i = 1; i <= 3; i++) begin
            chk("R2 order", 32'(b_rx_data), 32'(16'hA000 + i));
            b_rx_rd = 1; cyc();
        end

        // R3/R4: fill to depth and overflow
        for (int i = 0; i < DEPTH; i++) push_a(16'h1100 + 16'(i));
        chk("R3 full count", 32'(a_status[4:0]), 32'h18);
        push_a(16'hDEAD);
        chk("R4 err set", 32'(a_status[12]), 32'd1);
        chk("R4 count held", 32'(a_status[3:0]), 32'd8);
        chk("R4 head kept", 32'(b_rx_data), 32'h1100);

        // R6: clear by write-one
        a_ctl_wr = 1; a_ctl_wdata = 16'h0001; cyc();
        chk("R6 err cleared", 32'(a_status[12]), 32'd0);

        // R11: push+pop on full queue
        a_tx_wr = 1; a_tx_data = 16'hBEEF; b_rx_rd = 1; cyc();
        chk("R11 count", 32'(a_status[3:0]), 32'd7);
        chk("R11 err", 32'(a_status[12]), 32'd1);
        // R6: fault and clear together, fault wins
        a_tx_wr = 1; a_tx_data = 16'h2222; cyc();  // count 8
        a_tx_wr = 1; a_ctl_wr = 1; a_ctl_wdata = 16'h0001; cyc();
        chk("R6 set wins", 32'(a_status[12]), 32'd1);
        // R11: push+pop mid-level keeps count
        b_rx_rd = 1; cyc();
        a_tx_wr = 1; a_tx_data = 16'h3333; b_rx_rd = 1; cyc();
        chk("R11 steady count", 32'(b_status[9:6]), 32'd7);

        // R5: underflow from B side
        while (qab.size() > 0) begin b_rx_rd = 1; cyc(); end
        b_rx_rd = 1; cyc();
        chk("R5 b err", 32'(b_status[12]), 32'd1);
        chk("R5 still empty", 32'(b_status[9:6]), 32'd0);

        // R7: cross interrupts, one cycle
        a_ctl_wr = 1; a_ctl_wdata = 16'h0100; cyc();
        chk("R7 b_ipint high", 32'(b_ipint), 32'd1);
        chk("R7 req pending", 32'(a_status[13]), 32'd1);
        cyc();
        chk("R7 b_ipint low", 32'(b_ipint), 32'd0);
        b_ctl_wr = 1; b_ctl_wdata = 16'h0101; cyc();
        chk("R7 a_ipint high", 32'(a_ipint), 32'd1);
        chk("R6 b cleared", 32'(b_status[12]), 32'd0);

        // Random traffic in both directions (R2, R3, R8 compared every cycle)
        for (int n = 0; n < 600; n++) begin
            a_tx_wr = ($urandom % 3) != 0; a_tx_data = 16'($urandom);
            b_tx_wr = ($urandom % 2) != 0; b_tx_data = 16'($urandom);
            a_rx_rd = ($urandom % 2) != 0;
            b_rx_rd = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) begin a_ctl_wr = 1; a_ctl_wdata = 16'($urandom) & 16'h0101; end
            if (($urandom % 16) == 0) begin b_ctl_wr = 1; b_ctl_wdata = 16'($urandom) & 16'h0101; end
            cyc();
        end

        // R1: reset mid-traffic empties everything
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
        qab.delete(); qba.delete(); m_err_a = 0; m_err_b = 0; m_req_a = 0; m_req_b = 0;
        chk("R1 post reset a", 32'(a_status), 32'(exp_stat(0, 0, 0, 0)));
        chk("R1 post reset b", 32'(b_status), 32'(exp_stat(0, 0, 0, 0)));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule